// File: doc/BRIEF.md
# USB Frame Number Tracker

This block keeps the current 11-bit frame number and 3-bit micro-frame number for a USB peripheral. It sits behind the token decoder and integrity checker. It takes their results: a strobe that marks a start-of-frame token with its frame field, a flag that marks a start-of-frame token that failed its checks, and a tick from a free-running interpolation timer. The frame number changes only when a start-of-frame token arrives intact. Tokens that are lost or damaged leave it at its last value. The interpolation timer never moves it.

Each intact token either carries a new frame number or repeats the stored one. A new number is captured and the micro-frame count restarts at zero. A repeated number marks another micro-frame, so the micro-frame count steps by one and wraps after 7. A one-cycle event pulse reports every accepted token. When the tick-event mode input is high, it also reports every interpolation tick, so that downstream logic can keep a frame cadence across missing tokens.

Top module: `sof_frame_tracker`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `frame_num_o` and `uframe_num_o` are 0 and `sof_event_o` is 0.
- R2: A token is accepted when `sof_valid_i` is 1 and `sof_corrupt_i` is 0. If the accepted token's frame field differs from `frame_num_o`, then on the next cycle `frame_num_o` equals that field and `uframe_num_o` is 0.
- R3: If an accepted token's frame field equals `frame_num_o`, then on the next cycle `frame_num_o` is unchanged and `uframe_num_o` is one higher.
- R4: `uframe_num_o` wraps from 7 to 0 on an accepted token that repeats the stored frame number.
- R5: A cycle with `sof_corrupt_i` high changes neither `frame_num_o` nor `uframe_num_o`, even when `sof_valid_i` is also high.
- R6: `interp_tick_i` never changes `frame_num_o` or `uframe_num_o`, whatever the value of `tick_event_en_i`.
- R7: `sof_event_o` is high for exactly the one cycle after each accepted token.
- R8: With `tick_event_en_i` at 1, `sof_event_o` is also high in the cycle after an `interp_tick_i`. With it at 0, a tick gives no pulse.
- R9: A rejected token (corrupt flag high) produces no `sof_event_o` pulse.
- R10: An accepted token and a tick in the same cycle give a single one-cycle pulse, and the token is processed as in R2/R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof_valid_i | input | 1 | Start-of-frame token strobe |
| sof_frame_i | input | 11 | Frame field of the token |
| sof_corrupt_i | input | 1 | Token failed integrity checks |
| interp_tick_i | input | 1 | Interpolation timer tick |
| tick_event_en_i | input | 1 | 1: ticks also raise the event pulse |
| frame_num_o | output | 11 | Current frame number |
| uframe_num_o | output | 3 | Current micro-frame number |
| sof_event_o | output | 1 | One-cycle frame event pulse |

## Verification
The bench sends repeated frame numbers past eight micro-frames to check the wrap. A design that saturated the count, or restarted it at the wrong value, would show a wrong count after the eighth token. The bench raises the corrupt flag together with a valid strobe that carries a new frame number. A design that let the strobe win would capture that number and pulse. It drives ticks in both modes and across long gaps with no tokens. A design that counted ticks as frames would drift the frame number, and one that ignored the mode would pulse or stay silent wrongly. It also lands a token and a tick in the same cycle, which exposes a doubled pulse or a dropped update.

// File: rtl/sof_trk_pkg.sv
package sof_trk_pkg;

    localparam int FRAME_W  = 11;
    localparam int UFRAME_W = 3;

    typedef logic [FRAME_W-1:0]  frame_t;
    typedef logic [UFRAME_W-1:0] uframe_t;

    typedef struct packed {
        frame_t  frame;
        uframe_t uframe;
    } trk_state_t;

    typedef enum logic [1:0] {
        UPD_HOLD    = 2'd0,
        UPD_CAPTURE = 2'd1,
        UPD_ADVANCE = 2'd2
    } upd_kind_t;

    function automatic logic sof_accepted(input logic valid, input logic corrupt);
        return valid & ~corrupt;
    endfunction

    function automatic upd_kind_t classify(input logic accepted,
                                           input frame_t incoming,
                                           input frame_t stored);
        if (!accepted)
            return UPD_HOLD;
        else if (incoming != stored)
            return UPD_CAPTURE;
        else
            return UPD_ADVANCE;
    endfunction

endpackage

// File: rtl/sof_trk_update.sv
module sof_trk_update
    import sof_trk_pkg::*;
(
    input  trk_state_t cur_i,
    input  logic       accepted_i,
    input  frame_t     frame_i,
    output trk_state_t nxt_o,
    output upd_kind_t  kind_o
);

    upd_kind_t kind;

    always_comb begin
        kind  = classify(accepted_i, frame_i, cur_i.frame);
        nxt_o = cur_i;
        unique case (kind)
            UPD_CAPTURE: begin
                nxt_o.frame  = frame_i;
                nxt_o.uframe = '0;
            end
            UPD_ADVANCE: begin
                nxt_o.uframe = cur_i.uframe + uframe_t'(1);
            end
            default: begin
                nxt_o = cur_i;
            end
        endcase
    end

    assign kind_o = kind;

endmodule

// File: rtl/sof_trk_event.sv
module sof_trk_event (
    input  logic clk,
    input  logic rst,
    input  logic accepted_i,
    input  logic tick_i,
    input  logic tick_en_i,
    output logic event_o
);

    logic event_q;

    always_ff @(posedge clk) begin
        if (rst)
            event_q <= 1'b0;
        else
            event_q <= accepted_i | (tick_i & tick_en_i);
    end

    assign event_o = event_q;

endmodule

// File: rtl/sof_frame_tracker.sv
module sof_frame_tracker
    import sof_trk_pkg::*;
#(
    parameter int FW = FRAME_W,
    parameter int UW = UFRAME_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sof_valid_i,
    input  logic [FW-1:0] sof_frame_i,
    input  logic          sof_corrupt_i,
    input  logic          interp_tick_i,
    input  logic          tick_event_en_i,
    output logic [FW-1:0] frame_num_o,
    output logic [UW-1:0] uframe_num_o,
    output logic          sof_event_o
);

    trk_state_t state_q;
    trk_state_t state_d;
    upd_kind_t  upd_kind;
    logic       accepted;

    assign accepted = sof_accepted(sof_valid_i, sof_corrupt_i);

    sof_trk_update u_update (
        .cur_i      (state_q),
        .accepted_i (accepted),
        .frame_i    (frame_t'(sof_frame_i)),
        .nxt_o      (state_d),
        .kind_o     (upd_kind)
    );

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= '0;
        else if (upd_kind != UPD_HOLD)
            state_q <= state_d;
    end

    sof_trk_event u_event (
        .clk       (clk),
        .rst       (rst),
        .accepted_i(accepted),
        .tick_i    (interp_tick_i),
        .tick_en_i (tick_event_en_i),
        .event_o   (sof_event_o)
    );

    assign frame_num_o  = FW'(state_q.frame);
    assign uframe_num_o = UW'(state_q.uframe);

endmodule

// File: rtl/sof_frame_tracker_chk.sv
module sof_frame_tracker_chk #(
    parameter int FW = 11,
    parameter int UW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          sof_valid_i,
    input logic [FW-1:0] sof_frame_i,
    input logic          sof_corrupt_i,
    input logic          interp_tick_i,
    input logic          tick_event_en_i,
    input logic [FW-1:0] frame_num_o,
    input logic [UW-1:0] uframe_num_o,
    input logic          sof_event_o
);

    logic acc;
    assign acc = sof_valid_i & ~sof_corrupt_i;

    // R1
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (frame_num_o == '0 && uframe_num_o == '0 && !sof_event_o));

    // R2
    p_capture_r2: assert property (@(posedge clk) disable iff (rst)
        (acc && sof_frame_i != frame_num_o) |=>
        (frame_num_o == $past(sof_frame_i) && uframe_num_o == '0));

    // R3
    p_advance_r3: assert property (@(posedge clk) disable iff (rst)
        (acc && sof_frame_i == frame_num_o) |=>
        ($stable(frame_num_o) && uframe_num_o == UW'($past(uframe_num_o) + 1'b1)));

    // R4
    p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (acc && sof_frame_i == frame_num_o && uframe_num_o == '1) |=> (uframe_num_o == '0));

    // R5 and R6
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !acc |=> ($stable(frame_num_o) && $stable(uframe_num_o)));

    // R7 and R10
    p_event_r7: assert property (@(posedge clk) disable iff (rst)
        acc |=> sof_event_o);

    // R8 and R9
    p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (!acc && !(interp_tick_i && tick_event_en_i)) |=> !sof_event_o);

    // R8
    p_tick_r8: assert property (@(posedge clk) disable iff (rst)
        (interp_tick_i && tick_event_en_i) |=> sof_event_o);

endmodule

bind sof_frame_tracker sof_frame_tracker_chk #(.FW(FW), .UW(UW)) u_chk (.*);

// File: tb/sof_frame_tracker_bench.sv
module sof_frame_tracker_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        sof_valid_i, sof_corrupt_i, interp_tick_i, tick_event_en_i;
    logic [10:0] sof_frame_i;
    logic [10:0] frame_num_o;
    logic [2:0]  uframe_num_o;
    logic        sof_event_o;

    int checks = 0;
    int failures = 0;
    int exp_frame = 0;
    int exp_uf = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sof_frame_tracker u_sof_frame_tracker (.*);

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one cycle: drive at negedge, compare at next negedge
    task automatic step(input string tag, input bit v, input int fr,
                        input bit c, input bit t, input bit m);
        bit acc;
        @(negedge clk);
        sof_valid_i = v; sof_frame_i = 11'(fr); sof_corrupt_i = c;
        interp_tick_i = t; tick_event_en_i = m;
        acc = v && !c;
        if (acc) begin
            if (fr != exp_frame) begin exp_frame = fr; exp_uf = 0; end
            else exp_uf = (exp_uf + 1) % 8;
        end
        @(negedge clk);
        sof_valid_i = 0; sof_corrupt_i = 0; interp_tick_i = 0;
        chk({tag, " frame"}, int'(frame_num_o), exp_frame);
        chk({tag, " uframe"}, int'(uframe_num_o), exp_uf);
        chk({tag, " event"}, int'(sof_event_o), (acc || (t && m)) ? 1 : 0);
    endtask

    task automatic idle_check(input string tag);
        @(negedge clk);
        chk({tag, " idle event"}, int'(sof_event_o), 0);
    endtask

    task automatic t_reset();
        rst = 1; sof_valid_i = 0; sof_frame_i = 0; sof_corrupt_i = 0;
        interp_tick_i = 0; tick_event_en_i = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 frame", int'(frame_num_o), 0);
        chk("R1 uframe", int'(uframe_num_o), 0);
        chk("R1 event", int'(sof_event_o), 0);
        exp_frame = 0; exp_uf = 0;
    endtask

    task automatic t_capture();
        step("R2 new frame", 1, 100, 0, 0, 0);
        idle_check("R7");
        step("R3 repeat", 1, 100, 0, 0, 0);
        step("R3 repeat2", 1, 100, 0, 0, 0);
        step("R2 restart", 1, 101, 0, 0, 0);
        step("R2 max", 1, 2047, 0, 0, 0);
        step("R2 back to 0", 1, 0, 0, 0, 0);
    endtask

    task automatic t_wrap();
        step("R2 set", 1, 555, 0, 0, 0);
        for (int i = 0; i < 9; i++) step("R4 wrap", 1, 555, 0, 0, 0);
    endtask

    task automatic t_corrupt();
        step("R5 corrupt new", 1, 77, 1, 0, 0);
        step("R9 corrupt same", 1, 555, 1, 0, 0);
        step("R5 flag alone", 0, 999, 1, 0, 1);
    endtask

    task automatic t_ticks();
        for (int i = 0; i < 5; i++) step("R6 tick mode0", 0, 0, 0, 1, 0);
        for (int i = 0; i < 5; i++) step("R8 tick mode1", 0, 0, 0, 1, 1);
        step("R6 tick plus corrupt", 1, 3, 1, 1, 1);
    endtask

    task automatic t_both();
        step("R10 same cycle new", 1, 1234, 0, 1, 1);
        idle_check("R10");
        step("R10 same cycle repeat", 1, 1234, 0, 1, 1);
        step("R7 back to back", 1, 1234, 0, 0, 1);
        step("R7 back to back2", 1, 1235, 0, 0, 1);
    endtask

    initial begin
        t_reset();
        t_capture();
        t_wrap();
        t_corrupt();
        t_ticks();
        t_both();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule